// File: doc/BRIEF.md
# Multi-Mode 8-Bit Timer Counter

This block is an 8-bit counter that advances on a periodic tick enable. A power-of-two prescaler thins that tick further, and each resulting step moves the count according to one of four modes:

- **Free-running:** plain wrap-around counting.
- **One-shot countdown:** counts down from the compare value.
- **Modulo:** counts up to the compare value, then wraps.
- **Up/down:** triangular counting between zero and the compare value, which gives centre-aligned periods.

Software uses a simple register-style control port. It can write a run bit to start or freeze the count, pulse a clear, choose the mode and the prescale ratio, and supply the compare value. The live count is always visible at an output.

Each mode has its own terminal event. That event sets a sticky event flag. The flag stays set until software writes a one to the flag-clear input. An interrupt request is the flag gated by a mask bit.

The control core is a four-state machine that tracks two things: whether the counter runs, and which way it moves.

| State | Meaning |
|---|---|
| `S_HALT_UP` | halted, will move upward |
| `S_HALT_DN` | halted, will move downward |
| `S_RUN_UP` | running, moving upward |
| `S_RUN_DN` | running, moving downward |

Its transitions are:

- **start** (any halted state to the matching running state)
- **stop** (any running state to the matching halted state)
- **turn-down** (`S_RUN_UP` to `S_RUN_DN`, when the up/down count reaches the compare value)
- **turn-up** (`S_RUN_DN` to `S_RUN_UP`, when the falling count reaches zero)
- **clear** (any downward state to its upward counterpart, with the run bit kept)

Top module: `mtmr_top`

## Requirements
- R1: The prescaler select `psel_i` (3 bits, value p) makes the count advance once per 2^p tick pulses while running, so the ratios are 1 to 128.
- R2: A run write with value 1 starts counting. A run write with value 0 freezes the count at its present value, and later ticks do not change it.
- R3: Mode 0 (free-running): the count increments and wraps from 0xFF to 0x00. The flag is set on the step that makes the count 0xFF.
- R4: Mode 1 (one-shot countdown): a run write of 1 loads the compare value into the count. Each step decrements it. The flag is set on the step that makes it 0x00. The count then stays at 0x00 until the next start, and a count that is already zero raises no event.
- R5: Mode 2 (modulo): the count increments until it equals the compare value. The following step returns it to 0x00 and sets the flag.
- R6: Mode 3 (up/down): the count rises from 0x00 to the compare value, then falls back. The flag is set each time the falling count reaches 0x00. A compare value of 0x00 holds the count at 0x00 with no event.
- R7: A clear pulse sets the count to 0x00 and forces the direction to up, whatever the run state.
- R8: The flag is sticky and is cleared by a one on `flag_clr_i`. A terminal event in the same cycle wins over the clear.
- R9: `irq_o` is high exactly when the flag is set and `irq_mask_i` is 1.
- R10: The prescaler phase restarts on clear and while halted, so the first step after a start comes a full prescaled period after the start.
- R11: After reset the count is 0x00, the flag and `irq_o` are low, the counter is halted, and the direction is up.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Periodic tick enable feeding the prescaler |
| run_wr_i | input | 1 | Write strobe for the run bit |
| run_val_i | input | 1 | Run bit value: 1 start, 0 halt |
| clear_i | input | 1 | Clear pulse: count to zero, direction up |
| mode_i | input | 2 | Mode: 0 free, 1 countdown, 2 modulo, 3 up/down |
| psel_i | input | SEL_W (3) | Prescale exponent |
| cmp_i | input | CNT_W (8) | Compare / terminal value |
| irq_mask_i | input | 1 | Interrupt enable for the flag |
| flag_clr_i | input | 1 | Write-one-to-clear for the flag |
| count_o | output | CNT_W (8) | Live count value |
| flag_o | output | 1 | Sticky terminal-event flag |
| irq_o | output | 1 | Interrupt request |

## Verification
Some properties are checked on every cycle:

- a halted counter holds its value;
- a clear yields a zero count and an upward direction on the next cycle;
- free-running steps add exactly one;
- a countdown sitting at zero stays there;
- a modulo step at the compare value returns to zero;
- each terminal event leaves the flag set, and a clear-flag write without an event leaves it low.

Other behaviour only the bench's scenarios can show:

- the prescale ratios;
- the exact turning points and event placement of the up/down triangle;
- the countdown load on start;
- the interrupt gating by the mask;
- the restart of the prescaler phase after a halt.

// File: rtl/mtmr_pkg.sv
package mtmr_pkg;

    typedef enum logic [1:0] {
        M_FREE = 2'd0,
        M_DOWN = 2'd1,
        M_MOD  = 2'd2,
        M_UPDN = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        S_HALT_UP = 2'd0,
        S_HALT_DN = 2'd1,
        S_RUN_UP  = 2'd2,
        S_RUN_DN  = 2'd3
    } state_e;

endpackage

// File: rtl/mtmr_prescale.sv
module mtmr_prescale #(
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             clr_i,
    input  logic             tick_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             step_o
);
    localparam int PCNT_W = (1 << SEL_W) - 1;

    logic [PCNT_W-1:0] pcnt_q;
    logic [PCNT_W-1:0] lim;
    logic              at_lim;

    // limit is 2^sel - 1: the low sel bits set
    always_comb begin
        for (int i = 0; i < PCNT_W; i++) begin
            lim[i] = (i < int'(sel_i));
        end
    end

    assign at_lim = (pcnt_q == lim);
    assign step_o = run_i && tick_i && at_lim;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt_q <= '0;
        end else if (clr_i || !run_i) begin
            pcnt_q <= '0;
        end else if (tick_i) begin
            pcnt_q <= at_lim ? '0 : pcnt_q + PCNT_W'(1);
        end
    end

    // R10
    prescale_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run_i || clr_i) |=> !step_o || (lim == '0));

endmodule

// File: rtl/mtmr_fsm.sv
module mtmr_fsm
    import mtmr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run_wr_i,
    input  logic run_val_i,
    input  logic clr_i,
    input  logic turn_dn_i,
    input  logic turn_up_i,
    output logic run_o,
    output logic dir_up_o
);
    state_e state_q, state_n;
    logic   cur_run, cur_up, run_n, up_n;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_HALT_UP;
        else        state_q <= state_n;
    end

    // next state: start/stop, clear, turn-down, turn-up
    always_comb begin
        unique case (state_q)
            S_HALT_UP: begin cur_run = 1'b0; cur_up = 1'b1; end
            S_HALT_DN: begin cur_run = 1'b0; cur_up = 1'b0; end
            S_RUN_UP:  begin cur_run = 1'b1; cur_up = 1'b1; end
            S_RUN_DN:  begin cur_run = 1'b1; cur_up = 1'b0; end
        endcase
        run_n = run_wr_i ? run_val_i : cur_run;
        if (clr_i)          up_n = 1'b1;
        else if (turn_dn_i) up_n = 1'b0;
        else if (turn_up_i) up_n = 1'b1;
        else                up_n = cur_up;
        if (run_n) state_n = up_n ? S_RUN_UP  : S_RUN_DN;
        else       state_n = up_n ? S_HALT_UP : S_HALT_DN;
    end

    // outputs
    always_comb begin
        run_o    = cur_run;
        dir_up_o = cur_up;
    end

    // R7
    clear_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> dir_up_o);

    // R2
    halt_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_wr_i && !run_val_i) |=> !run_o);

endmodule

// File: rtl/mtmr_count.sv
module mtmr_count
    import mtmr_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic             clr_i,
    input  logic             load_i,
    input  mode_e            mode_i,
    input  logic [CNT_W-1:0] cmp_i,
    input  logic             dir_up_i,
    output logic [CNT_W-1:0] count_o,
    output logic             evt_o,
    output logic             turn_dn_o,
    output logic             turn_up_o
);
    localparam logic [CNT_W-1:0] ONE    = CNT_W'(1);
    localparam logic [CNT_W-1:0] TOP_M1 = {{(CNT_W-1){1'b1}}, 1'b0};

    logic [CNT_W-1:0] count_q, nxt;
    logic             evt, tdn, tup;

    always_comb begin
        nxt = count_q;
        evt = 1'b0;
        tdn = 1'b0;
        tup = 1'b0;
        unique case (mode_i)
            M_FREE: begin
                nxt = count_q + ONE;
                evt = (count_q == TOP_M1);
            end
            M_DOWN: begin
                if (count_q != '0) begin
                    nxt = count_q - ONE;
                    evt = (count_q == ONE);
                end
            end
            M_MOD: begin
                if (count_q == cmp_i) begin
                    nxt = '0;
                    evt = 1'b1;
                end else begin
                    nxt = count_q + ONE;
                end
            end
            M_UPDN: begin
                if (dir_up_i) begin
                    if (count_q >= cmp_i) begin
                        if (count_q != '0) begin
                            nxt = count_q - ONE;
                            if (count_q == ONE) evt = 1'b1;
                            else                tdn = 1'b1;
                        end
                    end else begin
                        nxt = count_q + ONE;
                        tdn = (count_q + ONE == cmp_i);
                    end
                end else begin
                    if (count_q != '0) begin
                        nxt = count_q - ONE;
                        if (count_q == ONE) begin
                            evt = 1'b1;
                            tup = 1'b1;
                        end
                    end else begin
                        tup = 1'b1;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      count_q <= '0;
        else if (clr_i)  count_q <= '0;
        else if (load_i) count_q <= cmp_i;
        else if (step_i) count_q <= nxt;
    end

    assign count_o   = count_q;
    assign evt_o     = step_i && evt;
    assign turn_dn_o = step_i && tdn;
    assign turn_up_o = step_i && tup;

    // R3
    free_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && mode_i == M_FREE && !clr_i && !load_i)
        |=> count_q == $past(count_q) + ONE);

    // R4
    down_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i == M_DOWN && count_q == '0 && !load_i && !clr_i)
        |=> count_q == '0);

    // R5
    mod_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && mode_i == M_MOD && count_q == cmp_i && !clr_i && !load_i)
        |=> count_q == '0);

    // R7
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> count_q == '0);

endmodule

// File: rtl/mtmr_top.sv
module mtmr_top
    import mtmr_pkg::*;
#(
    parameter int CNT_W = 8,
    parameter int SEL_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick_i,
    input  logic             run_wr_i,
    input  logic             run_val_i,
    input  logic             clear_i,
    input  logic [1:0]       mode_i,
    input  logic [SEL_W-1:0] psel_i,
    input  logic [CNT_W-1:0] cmp_i,
    input  logic             irq_mask_i,
    input  logic             flag_clr_i,
    output logic [CNT_W-1:0] count_o,
    output logic             flag_o,
    output logic             irq_o
);
    mode_e mode;
    logic  run, dir_up, step, evt, turn_dn, turn_up, load, flag_q;

    assign mode = mode_e'(mode_i);
    assign load = run_wr_i && run_val_i && (mode == M_DOWN);

    mtmr_prescale #(.SEL_W(SEL_W)) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .clr_i  (clear_i),
        .tick_i (tick_i),
        .sel_i  (psel_i),
        .step_o (step)
    );

    mtmr_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_wr_i  (run_wr_i),
        .run_val_i (run_val_i),
        .clr_i     (clear_i),
        .turn_dn_i (turn_dn),
        .turn_up_i (turn_up),
        .run_o     (run),
        .dir_up_o  (dir_up)
    );

    mtmr_count #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .step_i    (step),
        .clr_i     (clear_i),
        .load_i    (load),
        .mode_i    (mode),
        .cmp_i     (cmp_i),
        .dir_up_i  (dir_up),
        .count_o   (count_o),
        .evt_o     (evt),
        .turn_dn_o (turn_dn),
        .turn_up_o (turn_up)
    );

    // sticky flag, event wins over clear
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          flag_q <= 1'b0;
        else if (evt)        flag_q <= 1'b1;
        else if (flag_clr_i) flag_q <= 1'b0;
    end

    assign flag_o = flag_q;
    assign irq_o  = flag_q && irq_mask_i;

    // R8
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> flag_o);

    // R8
    flag_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_clr_i && !evt) |=> !flag_o);

    // R2
    halt_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!run && !clear_i && !run_wr_i) |=> $stable(count_o));

endmodule

// File: tb/test_mtmr_top.sv
module test_mtmr_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0, run_wr = 1'b0, run_val = 1'b0, clear = 1'b0;
    logic [1:0] mode = 2'd0;
    logic [2:0] psel = 3'd0;
    logic [7:0] cmp = 8'd0;
    logic       mask = 1'b0, fclr = 1'b0;
    logic [7:0] count;
    logic       flag, irq;

    int compared = 0;
    int mismatched = 0;

    always #5 clk = ~clk;

    mtmr_top i_mtmr_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_i     (tick),
        .run_wr_i   (run_wr),
        .run_val_i  (run_val),
        .clear_i    (clear),
        .mode_i     (mode),
        .psel_i     (psel),
        .cmp_i      (cmp),
        .irq_mask_i (mask),
        .flag_clr_i (fclr),
        .count_o    (count),
        .flag_o     (flag),
        .irq_o      (irq)
    );

    typedef struct packed {
        logic [3:0]  req;
        logic [1:0]  mode;
        logic [2:0]  psel;
        logic [7:0]  cmp;
        logic [15:0] n;
        logic [7:0]  exp_cnt;
        logic        exp_flag;
    } vec_t;

    localparam int NV = 16;
    localparam vec_t VECS [NV] = '{
        '{4'd3, 2'd0, 3'd0, 8'd0,  16'd5,   8'h05, 1'b0}, // R3
        '{4'd3, 2'd0, 3'd0, 8'd0,  16'd255, 8'hFF, 1'b1}, // R3 reach top
        '{4'd3, 2'd0, 3'd0, 8'd0,  16'd256, 8'h00, 1'b1}, // R3 wrap
        '{4'd4, 2'd1, 3'd0, 8'd10, 16'd4,   8'h06, 1'b0}, // R4 load + down
        '{4'd4, 2'd1, 3'd0, 8'd10, 16'd12,  8'h00, 1'b1}, // R4 hold at zero
        '{4'd5, 2'd2, 3'd0, 8'd4,  16'd4,   8'h04, 1'b0}, // R5
        '{4'd5, 2'd2, 3'd0, 8'd4,  16'd5,   8'h00, 1'b1}, // R5 wrap
        '{4'd5, 2'd2, 3'd0, 8'd4,  16'd7,   8'h02, 1'b1}, // R5
        '{4'd6, 2'd3, 3'd0, 8'd3,  16'd3,   8'h03, 1'b0}, // R6 peak
        '{4'd6, 2'd3, 3'd0, 8'd3,  16'd5,   8'h01, 1'b0}, // R6 falling
        '{4'd6, 2'd3, 3'd0, 8'd3,  16'd6,   8'h00, 1'b1}, // R6 bottom
        '{4'd6, 2'd3, 3'd0, 8'd3,  16'd8,   8'h02, 1'b1}, // R6 rising again
        '{4'd6, 2'd3, 3'd0, 8'd0,  16'd5,   8'h00, 1'b0}, // R6 zero compare
        '{4'd1, 2'd0, 3'd2, 8'd0,  16'd10,  8'h02, 1'b0}, // R1 divide 4
        '{4'd1, 2'd0, 3'd7, 8'd0,  16'd300, 8'h02, 1'b0}, // R1 divide 128
        '{4'd4, 2'd1, 3'd0, 8'd0,  16'd3,   8'h00, 1'b0}  // R4 zero load
    };

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(input string tag, input logic [7:0] got, input logic [7:0] exp);
        compared++;
        if (got !== exp) begin
            mismatched++;
            $display("FAIL %s got %0h expected %0h", tag, got, exp);
        end
    endtask

    task automatic cfg(input logic [1:0] m, input logic [2:0] p, input logic [7:0] c);
        mode = m; psel = p; cmp = c; clear = 1'b1; fclr = 1'b1;
        cyc();
        clear = 1'b0; fclr = 1'b0;
    endtask

    task automatic start();
        run_wr = 1'b1; run_val = 1'b1;
        cyc();
        run_wr = 1'b0;
    endtask

    task automatic stop();
        run_wr = 1'b1; run_val = 1'b0;
        cyc();
        run_wr = 1'b0;
    endtask

    task automatic ticks(input int n);
        tick = 1'b1;
        repeat (n) cyc();
        tick = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11 reset state
        check("R11 count", count, 8'h00);
        check("R11 flag", {7'd0, flag}, 8'h00);
        check("R11 irq", {7'd0, irq}, 8'h00);
        rst_n = 1'b1;
        cyc();
        check("R11 count after release", count, 8'h00);

        for (int v = 0; v < NV; v++) begin
            cfg(VECS[v].mode, VECS[v].psel, VECS[v].cmp);
            start();
            ticks(int'(VECS[v].n));
            check($sformatf("R%0d vec%0d count", VECS[v].req, v), count, VECS[v].exp_cnt);
            check($sformatf("R%0d vec%0d flag", VECS[v].req, v), {7'd0, flag}, {7'd0, VECS[v].exp_flag});
            stop();
        end

        // R2 halt freezes count
        cfg(2'd0, 3'd0, 8'd0);
        start();
        ticks(5);
        stop();
        ticks(5);
        check("R2 frozen count", count, 8'h05);
        start();
        ticks(2);
        check("R2 resumed count", count, 8'h07);
        stop();

        // R7 clear resets count and direction
        cfg(2'd3, 3'd0, 8'd3);
        start();
        ticks(4);
        check("R7 before clear", count, 8'h02);
        clear = 1'b1;
        cyc();
        clear = 1'b0;
        check("R7 cleared count", count, 8'h00);
        ticks(1);
        check("R7 direction up", count, 8'h01);
        stop();

        // R9 interrupt gating
        cfg(2'd0, 3'd0, 8'd0);
        start();
        ticks(255);
        stop();
        check("R9 irq masked", {7'd0, irq}, 8'h00);
        mask = 1'b1;
        #1;
        check("R9 irq enabled", {7'd0, irq}, 8'h01);

        // R8 flag clear
        fclr = 1'b1;
        cyc();
        fclr = 1'b0;
        check("R8 flag cleared", {7'd0, flag}, 8'h00);
        check("R9 irq drops", {7'd0, irq}, 8'h00);
        mask = 1'b0;

        // R8 event beats clear
        cfg(2'd2, 3'd0, 8'd2);
        start();
        ticks(2);
        check("R8 setup count", count, 8'h02);
        tick = 1'b1; fclr = 1'b1;
        cyc();
        tick = 1'b0; fclr = 1'b0;
        check("R8 event priority flag", {7'd0, flag}, 8'h01);
        check("R8 wrap count", count, 8'h00);
        stop();

        // R10 prescaler phase restarts after halt
        cfg(2'd0, 3'd1, 8'd0);
        start();
        ticks(1);
        check("R10 half period", count, 8'h00);
        stop();
        cyc();
        start();
        ticks(1);
        check("R10 phase restarted", count, 8'h00);
        ticks(1);
        check("R10 full period", count, 8'h01);
        stop();

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule